// File: doc/BRIEF.md
# Memory-Channel Event Counter Unit

This block watches one memory-controller channel and counts its activity. It holds eight 48-bit counters. Each counter has its own 8-bit event code, which picks one of the controller's single-cycle event strobes. Code zero counts every clock. Two switches gate counting: a global run bit, and a per-counter enable bit. Both must be set for a counter to advance.

Software reaches the block through a plain register bus with a 12-bit address and 64-bit data. Writes take effect at the next clock edge, and reads are combinational from the address. Software can preload any counter and read it back. When a counter rolls over from all ones to zero, it sets a sticky status bit. The interrupt output is raised when any status bit has a mask bit of 0. Status bits are cleared by writing a 1 to them in a separate clear register.

Top module: `mc_evt_monitor`

## Requirements
- R1: After a synchronous reset, all counters, event codes, the run bit and the enable mask read 0, every status bit reads 0, the interrupt mask reads 0xFF and `irq` is low.
- R2: Counter i (i = 0..7) is read and written as a 64-bit register at 0xE00 + 8*i. A write loads bits 47:0 of the write data, and bits 63:48 of that write are ignored. Reads return the 48-bit value zero-extended.
- R3: Bit 0 of the control register at 0xEA0 is the global run bit. While it is 0, no counter changes except by a bus write.
- R4: The register at 0xE70 holds the enable mask, with bit i enabling counter i. A counter whose bit is 0 holds its value.
- R5: The event code of counter i is at 0xE74 + 4*i. Only bits 7:0 are kept, and a read returns them zero-extended. Code 0x00 counts every clock. A code c in 0x01..0x8F counts the cycles in which `evt_strobe[c]` is 1. Codes 0x90 and above never count.
- R6: An enabled, running counter that steps from all ones wraps to 0 and sets bit i of the status register at 0x52C.
- R7: `irq` is 1 exactly when some status bit i is 1 while bit i of the mask register at 0x528 is 0. A mask bit of 1 suppresses that counter's interrupt.
- R8: Writing 1 to bit i of the clear register at 0x530 clears status bit i, and 0 bits leave their status bits alone. Writes to the status register itself have no effect.
- R9: If a bus write to a counter and an increment of that counter fall on the same edge, the counter takes the written value.
- R10: If an overflow and a clear write hit the same status bit on the same edge, the bit stays set.
- R11: The register at 0x710 reads the `VERSION` parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| evt_strobe | input | NUM_EVT (144) | Single-cycle event strobes, indexed by event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach from the ports is a collision on a single edge. This happens when a counter wraps on the same edge that software clears its status bit, or when a preload lands on the same edge as an increment. To force the first case, the bench preloads a counter with all ones and issues the run write and the clear write back to back, so that the wrap falls on the clear edge. To force the second, it writes the counter while the counter is running, reads it before the next edge, and then reads it again once one more increment has happened. Wrap detection is reached in a few cycles by preloading a value just below all ones.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    localparam int NCNT   = 8;
    localparam int IDX_W  = $clog2(NCNT);
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 64;
    localparam int CODE_W = 8;

    localparam logic [ADDR_W-1:0] A_CNT_BASE = 12'hE00;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 12'hE74;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 12'hE70;
    localparam logic [ADDR_W-1:0] A_CTRL     = 12'hEA0;
    localparam logic [ADDR_W-1:0] A_IMASK    = 12'h528;
    localparam logic [ADDR_W-1:0] A_ISTAT    = 12'h52C;
    localparam logic [ADDR_W-1:0] A_ICLR     = 12'h530;
    localparam logic [ADDR_W-1:0] A_VERSION  = 12'h710;

    typedef enum logic [3:0] {
        RK_NONE, RK_CNT, RK_SEL, RK_CTRL, RK_EN,
        RK_IMASK, RK_ISTAT, RK_ICLR, RK_VER
    } mcm_rkind_t;

    typedef struct packed {
        mcm_rkind_t       kind;
        logic [IDX_W-1:0] idx;
    } mcm_slot_t;

    typedef struct packed {
        logic [NCNT-1:0] cnt;
        logic [NCNT-1:0] sel;
        logic            ctrl;
        logic            enable;
        logic            imask;
        logic            iclr;
    } mcm_wsel_t;

    function automatic mcm_slot_t decode_addr(input logic [ADDR_W-1:0] a);
        mcm_slot_t s;
        logic [ADDR_W-1:0] oc;
        logic [ADDR_W-1:0] os;
        s.kind = RK_NONE;
        s.idx  = '0;
        oc = a - A_CNT_BASE;
        os = a - A_SEL_BASE;
        if (oc < ADDR_W'(NCNT * 8) && oc[2:0] == 3'b000) begin
            s.kind = RK_CNT;
            s.idx  = oc[IDX_W+2:3];
        end else if (os < ADDR_W'(NCNT * 4) && os[1:0] == 2'b00) begin
            s.kind = RK_SEL;
            s.idx  = os[IDX_W+1:2];
        end else begin
            case (a)
                A_CTRL:    s.kind = RK_CTRL;
                A_ENABLE:  s.kind = RK_EN;
                A_IMASK:   s.kind = RK_IMASK;
                A_ISTAT:   s.kind = RK_ISTAT;
                A_ICLR:    s.kind = RK_ICLR;
                A_VERSION: s.kind = RK_VER;
                default:   s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/mcm_decode.sv
module mcm_decode
    import mcm_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output mcm_slot_t         slot,
    output mcm_wsel_t         wsel
);

    always_comb begin
        slot = decode_addr(bus_addr);
        wsel = '0;
        for (int i = 0; i < NCNT; i++) begin
            wsel.cnt[i] = bus_wr && slot.kind == RK_CNT && slot.idx == IDX_W'(i);
            wsel.sel[i] = bus_wr && slot.kind == RK_SEL && slot.idx == IDX_W'(i);
        end
        wsel.ctrl   = bus_wr && slot.kind == RK_CTRL;
        wsel.enable = bus_wr && slot.kind == RK_EN;
        wsel.imask  = bus_wr && slot.kind == RK_IMASK;
        wsel.iclr   = bus_wr && slot.kind == RK_ICLR;
    end

endmodule

// File: rtl/mcm_counter.sv
module mcm_counter
    import mcm_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 144
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               en,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               code_wr,
    input  logic [CODE_W-1:0]  code_in,
    input  logic [NUM_EVT-1:0] evt,
    output logic [CNT_W-1:0]   cnt,
    output logic [CODE_W-1:0]  code,
    output logic               wrap
);

    localparam int PAD_W = 1 << CODE_W;

    logic [PAD_W-1:0] evt_pad;
    logic             hit;
    logic             step;

    assign evt_pad = PAD_W'(evt);

    always_comb begin
        if (code == '0)
            hit = 1'b1;
        else
            hit = (int'(code) < NUM_EVT) && evt_pad[code];
    end

    assign step = run && en && hit;
    // a preload on the same edge suppresses both the step and the wrap
    assign wrap = step && !load && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            code <= '0;
        end else begin
            if (code_wr)
                code <= code_in;
            if (load)
                cnt <= load_val;
            else if (step)
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mcm_irq.sv
module mcm_irq
    import mcm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            mask_wr,
    input  logic            clr_wr,
    input  logic [NCNT-1:0] wbits,
    input  logic [NCNT-1:0] wrap,
    output logic [NCNT-1:0] status,
    output logic [NCNT-1:0] mask,
    output logic            irq
);

    logic [NCNT-1:0] clr_bits;

    assign clr_bits = clr_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            // a new overflow outranks a clear of the same bit
            status <= (status & ~clr_bits) | wrap;
            if (mask_wr)
                mask <= wbits;
        end
    end

    assign irq = |(status & ~mask);

endmodule

// File: rtl/mc_evt_monitor.sv
module mc_evt_monitor
    import mcm_pkg::*;
#(
    parameter int          CNT_W   = 48,
    parameter int          NUM_EVT = 144,
    parameter logic [31:0] VERSION = 32'h0000_0200
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);

    mcm_slot_t                   slot;
    mcm_wsel_t                   wsel;
    logic                        run_q;
    logic [NCNT-1:0]             en_q;
    logic [NCNT-1:0][CNT_W-1:0]  cnt_q;
    logic [NCNT-1:0][CODE_W-1:0] code_q;
    logic [NCNT-1:0]             wrap_v;
    logic [NCNT-1:0]             status_q;
    logic [NCNT-1:0]             mask_q;
    logic                        unused_bits;

    assign unused_bits = ^bus_wdata[BUS_W-1:CNT_W];

    mcm_decode u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .slot     (slot),
        .wsel     (wsel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            en_q  <= '0;
        end else begin
            if (wsel.ctrl)
                run_q <= bus_wdata[0];
            if (wsel.enable)
                en_q <= bus_wdata[NCNT-1:0];
        end
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        mcm_counter #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .run      (run_q),
            .en       (en_q[g]),
            .load     (wsel.cnt[g]),
            .load_val (bus_wdata[CNT_W-1:0]),
            .code_wr  (wsel.sel[g]),
            .code_in  (bus_wdata[CODE_W-1:0]),
            .evt      (evt_strobe),
            .cnt      (cnt_q[g]),
            .code     (code_q[g]),
            .wrap     (wrap_v[g])
        );
    end

    mcm_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_wr (wsel.imask),
        .clr_wr  (wsel.iclr),
        .wbits   (bus_wdata[NCNT-1:0]),
        .wrap    (wrap_v),
        .status  (status_q),
        .mask    (mask_q),
        .irq     (irq)
    );

    always_comb begin
        case (slot.kind)
            RK_CNT:   bus_rdata = BUS_W'(cnt_q[slot.idx]);
            RK_SEL:   bus_rdata = BUS_W'(code_q[slot.idx]);
            RK_CTRL:  bus_rdata = BUS_W'(run_q);
            RK_EN:    bus_rdata = BUS_W'(en_q);
            RK_IMASK: bus_rdata = BUS_W'(mask_q);
            RK_ISTAT: bus_rdata = BUS_W'(status_q);
            RK_VER:   bus_rdata = BUS_W'(VERSION);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mcm_checker.sv
module mcm_checker
    import mcm_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [BUS_W-1:0]           bus_wdata,
    input logic                       run,
    input logic [NCNT-1:0]            en,
    input logic [NCNT-1:0]            load,
    input logic [NCNT-1:0][CNT_W-1:0] cnt,
    input logic [NCNT-1:0]            wrap,
    input logic [NCNT-1:0]            status,
    input logic [NCNT-1:0]            mask,
    input logic                       irq
);

    logic clr_write;
    assign clr_write = bus_wr && bus_addr == A_ICLR;

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '1 && status == '0 && cnt == '0 && !irq));

    // R3
    a_r3_halt_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && load == '0) |=> $stable(cnt));

    // R7
    a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);

    for (genvar i = 0; i < NCNT; i++) begin : g_chk
        // R4
        a_r4_disabled_holds: assert property (@(posedge clk) disable iff (rst)
            (!en[i] && !load[i]) |=> $stable(cnt[i]));
        // R6 and R10
        a_r6_wrap_sets_status: assert property (@(posedge clk) disable iff (rst)
            wrap[i] |=> status[i]);
        // R8
        a_r8_clear_drops_bit: assert property (@(posedge clk) disable iff (rst)
            (clr_write && bus_wdata[i] && !wrap[i]) |=> !status[i]);
        a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !(clr_write && bus_wdata[i])) |=> status[i]);
        // R9
        a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
            load[i] |=> cnt[i] == $past(bus_wdata[CNT_W-1:0]));
    end

endmodule

bind mc_evt_monitor mcm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run_q),
    .en        (en_q),
    .load      (wsel.cnt),
    .cnt       (cnt_q),
    .wrap      (wrap_v),
    .status    (status_q),
    .mask      (mask_q),
    .irq       (irq)
);

// File: tb/test_mc_evt_monitor.sv
`timescale 1ns/1ps
module test_mc_evt_monitor;

    localparam int NEVT = 144;

    logic            clk = 1'b0;
    logic            rst;
    logic [11:0]     bus_addr;
    logic            bus_wr;
    logic [63:0]     bus_wdata;
    logic [63:0]     bus_rdata;
    logic [NEVT-1:0] evt_strobe;
    logic            irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mc_evt_monitor i_mc_evt_monitor (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_strobe = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; the write lands on the next posedge, returns at the negedge after it
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset_state();
        logic [63:0] d;
        do_reset();
        rd(12'hEA0, d); check("R1 run bit", d, 64'h0);
        rd(12'hE70, d); check("R1 enable mask", d, 64'h0);
        rd(12'h528, d); check("R1 irq mask", d, 64'hFF);
        rd(12'h52C, d); check("R1 status", d, 64'h0);
        rd(12'hE78, d); check("R1 event code", d, 64'h0);
        for (int i = 0; i < 8; i++) begin
            rd(12'hE00 + 12'(8 * i), d); check("R1 counter", d, 64'h0);
        end
        check("R1 irq low", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_preload();
        logic [63:0] d;
        logic [63:0] v;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            v = 64'hFFFF_0000_0000_0000 | (64'(i + 1) * 64'h1111_1111);
            wr(12'hE00 + 12'(8 * i), v);
        end
        for (int i = 0; i < 8; i++) begin
            v = 64'(i + 1) * 64'h1111_1111;
            rd(12'hE00 + 12'(8 * i), d); check("R2 preload readback", d, v);
        end
    endtask

    task automatic t_gating();
        logic [63:0] d;
        do_reset();
        wr(12'hE70, 64'h01);
        idle(10);
        rd(12'hE00, d); check("R3 stopped counter", d, 64'h0);
        wr(12'hEA0, 64'h1);
        idle(4);
        wr(12'hEA0, 64'h0);
        rd(12'hE00, d); check("R3 counts while running", d, 64'd5);
        rd(12'hE08, d); check("R4 disabled counter holds", d, 64'h0);
        idle(5);
        rd(12'hE00, d); check("R3 holds after stop", d, 64'd5);
    endtask

    task automatic t_event_select();
        logic [63:0] d;
        do_reset();
        wr(12'hE78, 64'h83);
        wr(12'hE7C, 64'hABCD_0184);
        wr(12'hE80, 64'h95);
        rd(12'hE7C, d); check("R5 code low byte kept", d, 64'h84);
        wr(12'hE70, 64'h0E);
        wr(12'hEA0, 64'h1);
        for (int j = 0; j < 10; j++) begin
            evt_strobe = '0;
            evt_strobe[8'h83] = (j % 2 == 0);
            evt_strobe[8'h84] = (j < 3);
            evt_strobe[8'h10] = 1'b1;
            @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            evt_strobe = '1;
            @(negedge clk);
        end
        evt_strobe = '0;
        wr(12'hEA0, 64'h0);
        rd(12'hE08, d); check("R5 code 0x83", d, 64'd9);
        rd(12'hE10, d); check("R5 code 0x84", d, 64'd7);
        rd(12'hE18, d); check("R5 invalid code", d, 64'd0);
        rd(12'hE00, d); check("R4 masked counter", d, 64'd0);
    endtask

    task automatic t_overflow_irq();
        logic [63:0] d;
        do_reset();
        wr(12'hE10, 64'h0000_FFFF_FFFF_FFFD);
        wr(12'hE70, 64'h04);
        wr(12'hEA0, 64'h1);
        idle(1);
        wr(12'hEA0, 64'h0);
        rd(12'hE10, d); check("R6 reaches all ones", d, 64'h0000_FFFF_FFFF_FFFF);
        rd(12'h52C, d); check("R6 no status before wrap", d, 64'h0);
        wr(12'hEA0, 64'h1);
        wr(12'hEA0, 64'h0);
        rd(12'hE10, d); check("R6 wraps to zero", d, 64'h0);
        rd(12'h52C, d); check("R6 status set", d, 64'h04);
        check("R7 masked irq low", {63'h0, irq}, 64'h0);
        wr(12'h528, 64'hFB);
        check("R7 unmasked irq high", {63'h0, irq}, 64'h1);
        wr(12'h528, 64'hFF);
        check("R7 remasked irq low", {63'h0, irq}, 64'h0);
        wr(12'h528, 64'hFB);
        wr(12'h52C, 64'h0);
        rd(12'h52C, d); check("R8 status write ignored", d, 64'h04);
        wr(12'h530, 64'h00);
        rd(12'h52C, d); check("R8 zero clear no effect", d, 64'h04);
        wr(12'h530, 64'h08);
        rd(12'h52C, d); check("R8 other bit clear", d, 64'h04);
        wr(12'h530, 64'h04);
        rd(12'h52C, d); check("R8 clear drops bit", d, 64'h0);
        check("R7 irq low after clear", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_write_wins();
        logic [63:0] d;
        do_reset();
        wr(12'hE70, 64'h01);
        wr(12'hEA0, 64'h1);
        idle(3);
        wr(12'hE00, 64'd100);
        rd(12'hE00, d); check("R9 write beats increment", d, 64'd100);
        wr(12'hEA0, 64'h0);
        rd(12'hE00, d); check("R9 counting resumes", d, 64'd101);
    endtask

    task automatic t_same_cycle_clear();
        logic [63:0] d;
        do_reset();
        wr(12'hE00, 64'h0000_FFFF_FFFF_FFFF);
        wr(12'hE70, 64'h01);
        wr(12'hEA0, 64'h1);
        wr(12'h530, 64'h01);
        wr(12'hEA0, 64'h0);
        rd(12'hE00, d); check("R10 counter after wrap", d, 64'd1);
        rd(12'h52C, d); check("R10 overflow beats clear", d, 64'h01);
        wr(12'h530, 64'h01);
        rd(12'h52C, d); check("R8 later clear works", d, 64'h0);
    endtask

    task automatic t_version();
        logic [63:0] d;
        do_reset();
        rd(12'h710, d); check("R11 version value", d, 64'h0000_0200);
        wr(12'h710, 64'hFFFF_FFFF);
        rd(12'h710, d); check("R11 version write ignored", d, 64'h0000_0200);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_preload();
        t_gating();
        t_event_select();
        t_overflow_irq();
        t_write_wins();
        t_same_cycle_clear();
        t_version();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule